// File: doc/BRIEF.md
# Two-Wire Bus Target Register Port

This block is a target on a two-wire serial management bus. A host reaches a small internal register file through it: several 16-bit word registers that can be written and read back, and one block register. The block register is a fixed byte array whose contents are set by parameters, and it is returned with a length byte in front. The block samples the clock and data lines with a fast system clock. It recognises start and stop conditions and answers one fixed 7-bit target address. The command byte that follows the address selects one of three transfers: word write, word read, or block read.

The data line uses open-drain semantics. The block only ever asks for the line to be pulled low, through `sda_oe`. The pad or the bench forms the wired-AND of that request with the host's drive and the pull-up. When the enable input is low the block releases the line and ignores all bus activity.

Top module: `smb_regport`

## Requirements
- R1: A start condition (data falls while the clock is high) begins a new address phase at any time, including in the middle of a transfer as a repeated start. A stop condition (data rises while the clock is high) returns the block to idle, and a word write cut short by a stop leaves the register unchanged.
- R2: The first byte after a start carries the address in bits 7..1 and the read flag in bit 0 (1 = read). The address is 7'h0B (first byte 8'h16 for write, 8'h17 for read). Any other address is not acknowledged, and every later byte is ignored until the next start.
- R3: Each byte is shifted most-significant bit first in both directions. Each byte is acknowledged on the ninth clock by the block pulling the data line low while the clock is high.
- R4: A word write is: address with write flag, command, low byte, high byte, and each of these four bytes is acknowledged. The register selected by the command then holds {high, low}. A fifth byte is not acknowledged.
- R5: A word read is: address with write flag, command, repeated start, address with read flag. The block then returns the low byte and then the high byte of the selected register.
- R6: A block read uses command 8'h20 in the same sequence as a word read. The block returns a count byte equal to 6, then data bytes k = 0..5 with value (8'h30 + 7*k) mod 256.
- R7: Only commands 8'h00..8'h03 (the four word registers) and 8'h20 are acknowledged. A data byte written after command 8'h20 is not acknowledged and changes nothing.
- R8: An address with the read flag is not acknowledged unless an accepted command came earlier in the same transfer, before any stop.
- R9: A not-acknowledge from the host on a read byte ends the read. The block drives nothing on further clocks, so the host sees 8'hFF.
- R10: While `en` is low the block releases the line within one clock, acknowledges nothing and writes no register.
- R11: After reset the line is released and word register i holds 16'hA500 + i.
- R12: The block starts pulling the data line low only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Target enable; low releases the line and ignores the bus |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 requests the data line be pulled low; 0 releases it |

## Verification
The assertions rely on the host holding the clock low for several system clocks after each falling edge. The block needs that time to see the edge through its synchronisers before it drives a bit or an acknowledge, so a clock-high check on a new drive holds only under that pacing. They also rely on the host changing the data line only while the clock is low, except for deliberate start and stop conditions. The stimulus holds each clock phase for eight system clocks and always moves data one clock after a falling edge. Before a repeated start it waits a full phase, so that the target's acknowledge has been released before the clock rises.

// File: rtl/smb_pkg.sv
package smb_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WLO,
      ST_WHI,
      ST_TX,
      ST_DONE
   } smb_st_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/smb_edge.sv
module smb_edge
   import smb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output logic    scl_s,
   output bus_ev_t ev
);

   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] scl_sy, sda_sy;
   logic         scl_d, sda_d, sda_s;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("smb_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_sy <= '1;
         sda_sy <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sy <= {scl_sy[MSB-1:0], scl_i};
         sda_sy <= {sda_sy[MSB-1:0], sda_i};
         scl_d  <= scl_sy[MSB];
         sda_d  <= sda_sy[MSB];
      end
   end

   assign scl_s = scl_sy[MSB];
   assign sda_s = sda_sy[MSB];

   always_comb begin
      ev.rise  = scl_s & ~scl_d;
      ev.fall  = ~scl_s & scl_d;
      ev.start = scl_s & scl_d & sda_d & ~sda_s;
      ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
      ev.sda   = sda_s;
   end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
   import smb_pkg::*;
#(
   parameter int                 NUM_WORDS = 4,
   parameter int                 AW        = 2,
   parameter logic [WORD_W-1:0]  WORD_RST  = 16'hA500,
   parameter int                 BLK_LEN   = 6,
   parameter logic [7:0]         BLK_SEED  = 8'h30,
   parameter logic [7:0]         BLK_STEP  = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   input  logic [7:0]        bidx,
   output logic [WORD_W-1:0] rword,
   output logic [7:0]        bbyte
);

   logic [WORD_W-1:0] regs [NUM_WORDS];
   logic [7:0]        blk_mem [BLK_LEN];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (!rst_n)
            regs[i] <= WORD_RST + WORD_W'(i);
         else if (we && waddr == AW'(i))
            regs[i] <= wdata;
      end
   end

   generate
      for (genvar k = 0; k < BLK_LEN; k++) begin : g_blk
         assign blk_mem[k] = BLK_SEED + 8'(k) * BLK_STEP;
      end
   endgenerate

   always_comb begin
      rword = '0;
      for (int i = 0; i < NUM_WORDS; i++)
         if (raddr == AW'(i)) rword = regs[i];
   end

   always_comb begin
      bbyte = 8'hFF;
      for (int k = 0; k < BLK_LEN; k++)
         if (bidx == 8'(k)) bbyte = blk_mem[k];
   end

endmodule

// File: rtl/smb_link.sv
module smb_link
   import smb_pkg::*;
#(
   parameter logic [6:0] ADDR7     = 7'h0B,
   parameter int         NUM_WORDS = 4,
   parameter int         AW        = 2,
   parameter logic [7:0] BLK_CMD   = 8'h20,
   parameter int         BLK_LEN   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  bus_ev_t           ev,
   input  logic [WORD_W-1:0] rword,
   input  logic [7:0]        bbyte,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] wdata,
   output logic [7:0]        bidx,
   output logic              sda_oe,
   output smb_st_e           st,
   output logic [3:0]        bcnt
);

   localparam logic [7:0] NW8      = 8'(NUM_WORDS);
   localparam logic [7:0] BLK_LEN8 = 8'(BLK_LEN);

   smb_st_e    nst, nxt;
   logic [7:0] shreg, txb, cmd, lo, txi, byte_sel;
   logic       have_cmd, is_blk, oe, acc;

   assign waddr  = cmd[AW-1:0];
   assign raddr  = cmd[AW-1:0];
   assign bidx   = txi - 8'd1;
   assign sda_oe = oe;

   // next byte to send, indexed by txi
   always_comb begin
      if (is_blk)
         byte_sel = (txi == 8'd0) ? BLK_LEN8 : bbyte;
      else if (txi == 8'd0)
         byte_sel = rword[7:0];
      else if (txi == 8'd1)
         byte_sel = rword[15:8];
      else
         byte_sel = 8'hFF;
   end

   // accept decision for a completed received byte
   always_comb begin
      acc = 1'b0;
      nxt = ST_DONE;
      case (st)
         ST_ADDR: if (shreg[7:1] == ADDR7 && (!shreg[0] || have_cmd)) begin
            acc = 1'b1;
            nxt = shreg[0] ? ST_TX : ST_CMD;
         end
         ST_CMD: if (shreg < NW8 || shreg == BLK_CMD) begin
            acc = 1'b1;
            nxt = ST_WLO;
         end
         ST_WLO: if (!is_blk) begin
            acc = 1'b1;
            nxt = ST_WHI;
         end
         ST_WHI: begin
            acc = 1'b1;
            nxt = ST_DONE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;   nst <= ST_IDLE;
         bcnt <= '0;      oe <= 1'b0;     we <= 1'b0;
         shreg <= '0;     txb <= '1;      cmd <= '0;
         lo <= '0;        txi <= '0;      wdata <= '0;
         have_cmd <= 1'b0; is_blk <= 1'b0;
      end else if (!en) begin
         st <= ST_IDLE;
         bcnt <= '0;
         oe <= 1'b0;
         we <= 1'b0;
         have_cmd <= 1'b0;
      end else begin
         we <= 1'b0;
         if (ev.start) begin
            st <= ST_ADDR;
            bcnt <= '0;
            oe <= 1'b0;
         end else if (ev.stop) begin
            st <= ST_IDLE;
            oe <= 1'b0;
            have_cmd <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_CMD, ST_WLO, ST_WHI: begin
                  if (ev.rise && bcnt < 4'd8) begin
                     shreg <= {shreg[6:0], ev.sda};
                     bcnt  <= bcnt + 4'd1;
                  end
                  if (ev.fall && bcnt == 4'd8) begin
                     if (acc) begin
                        oe   <= 1'b1;
                        bcnt <= 4'd9;
                        nst  <= nxt;
                        case (st)
                           ST_ADDR: begin
                              txi <= '0;
                              if (!shreg[0]) have_cmd <= 1'b0;
                           end
                           ST_CMD: begin
                              cmd      <= shreg;
                              have_cmd <= 1'b1;
                              is_blk   <= (shreg == BLK_CMD);
                           end
                           ST_WLO:  lo <= shreg;
                           default: begin
                              we    <= 1'b1;
                              wdata <= {shreg, lo};
                           end
                        endcase
                     end else begin
                        st   <= ST_DONE;
                        bcnt <= '0;
                     end
                  end else if (ev.fall && bcnt == 4'd9) begin
                     bcnt <= '0;
                     st   <= nst;
                     if (nst == ST_TX) begin
                        txb <= byte_sel;
                        oe  <= ~byte_sel[7];
                        txi <= txi + 8'd1;
                     end else begin
                        oe <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (ev.rise && bcnt == 4'd8 && ev.sda) st <= ST_DONE;
                  if (ev.fall) begin
                     if (bcnt < 4'd7) begin
                        bcnt <= bcnt + 4'd1;
                        txb  <= {txb[6:0], 1'b1};
                        oe   <= ~txb[6];
                     end else if (bcnt == 4'd7) begin
                        oe   <= 1'b0;
                        bcnt <= 4'd8;
                     end else begin
                        txb  <= byte_sel;
                        oe   <= ~byte_sel[7];
                        txi  <= txi + 8'd1;
                        bcnt <= '0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_regport.sv
module smb_regport
   import smb_pkg::*;
#(
   parameter logic [6:0]        ADDR7       = 7'h0B,
   parameter int                NUM_WORDS   = 4,
   parameter logic [WORD_W-1:0] WORD_RST    = 16'hA500,
   parameter logic [7:0]        BLK_CMD     = 8'h20,
   parameter int                BLK_LEN     = 6,
   parameter logic [7:0]        BLK_SEED    = 8'h30,
   parameter logic [7:0]        BLK_STEP    = 8'h07,
   parameter int                SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);

   localparam int AW = $clog2(NUM_WORDS);

   generate
      if (NUM_WORDS < 2 || NUM_WORDS > 128) begin : g_bad_words
         $error("smb_regport: NUM_WORDS out of range");
      end
      if (int'(BLK_CMD) < NUM_WORDS) begin : g_bad_cmd
         $error("smb_regport: BLK_CMD overlaps word commands");
      end
      if (BLK_LEN < 1 || BLK_LEN > 32) begin : g_bad_len
         $error("smb_regport: BLK_LEN out of range");
      end
   endgenerate

   bus_ev_t           ev;
   logic              scl_sync;
   logic              reg_we;
   logic [AW-1:0]     waddr, raddr;
   logic [WORD_W-1:0] wdata, rword;
   logic [7:0]        bidx, bbyte;
   smb_st_e           link_st;
   logic [3:0]        link_bcnt;

   smb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_sync), .ev(ev)
   );

   smb_regfile #(
      .NUM_WORDS(NUM_WORDS), .AW(AW), .WORD_RST(WORD_RST),
      .BLK_LEN(BLK_LEN), .BLK_SEED(BLK_SEED), .BLK_STEP(BLK_STEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .bidx(bidx), .rword(rword), .bbyte(bbyte)
   );

   smb_link #(
      .ADDR7(ADDR7), .NUM_WORDS(NUM_WORDS), .AW(AW),
      .BLK_CMD(BLK_CMD), .BLK_LEN(BLK_LEN)
   ) u_link (
      .clk(clk), .rst_n(rst_n), .en(en), .ev(ev), .rword(rword), .bbyte(bbyte),
      .we(reg_we), .waddr(waddr), .raddr(raddr), .wdata(wdata), .bidx(bidx),
      .sda_oe(sda_oe), .st(link_st), .bcnt(link_bcnt)
   );

endmodule

// File: rtl/smb_regport_chk.sv
module smb_regport_chk
   import smb_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       scl_s,
   input logic       sda_oe,
   input smb_st_e    st,
   input logic [3:0] bcnt,
   input logic       we
);

   // R2: no drive while idle or after a refused byte
   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_DONE) |-> !sda_oe);

   // R12: a new low drive only begins while the clock is low
   p_drive_clk_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10: disable releases the line one clock later
   p_disable_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sda_oe);

   // R4: write strobe is a single pulse
   p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   // R4: write happens only while the high data byte is being acknowledged
   p_write_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (st == ST_WHI && bcnt == 4'd9));

   // R3: bit counter stays within a byte plus acknowledge
   p_bcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= 4'd9);

endmodule

bind smb_regport smb_regport_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .scl_s(scl_sync),
   .sda_oe(sda_oe), .st(link_st), .bcnt(link_bcnt), .we(reg_we)
);

// File: tb/smb_regport_tb.sv
module smb_regport_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam logic [7:0] AW_BYTE = 8'h16;
   localparam logic [7:0] AR_BYTE = 8'h17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic oe_prev = 1'b0;
   int   n_cmp = 0;
   int   n_bad = 0;
   int   n_oe_bad = 0;

   assign sda_line = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_regport u_dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
   );

   // R12 monitor: a new drive must not appear while the host holds the clock high
   always @(negedge clk) begin
      if (rst_n && sda_oe && !oe_prev && scl_m) n_oe_bad++;
      oe_prev <= sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b0; tick(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b1; tick(HALF);
   endtask

   task automatic put_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(HALF);
         scl_m = 1'b1; tick(HALF);
         scl_m = 1'b0; tick(1);
      end
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF/2);
      ack = !sda_line;
      tick(HALF/2);
      scl_m = 1'b0; tick(1);
   endtask

   task automatic get_byte(output logic [7:0] b, input bit nack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(HALF);
         scl_m = 1'b1; tick(HALF/2);
         b[i] = sda_line;
         tick(HALF/2);
         scl_m = 1'b0; tick(1);
      end
      sda_m = nack; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0; tick(1);
      sda_m = 1'b1;
   endtask

   task automatic wr_word(input logic [7:0] cmd, input logic [15:0] v,
                          output logic [3:0] acks);
      bus_start();
      put_byte(AW_BYTE, acks[3]);
      put_byte(cmd, acks[2]);
      put_byte(v[7:0], acks[1]);
      put_byte(v[15:8], acks[0]);
      bus_stop();
   endtask

   task automatic rd_word(input logic [7:0] cmd, output logic [15:0] v,
                          output logic [2:0] acks);
      bus_start();
      put_byte(AW_BYTE, acks[2]);
      put_byte(cmd, acks[1]);
      bus_start();
      put_byte(AR_BYTE, acks[0]);
      get_byte(v[7:0], 1'b0);
      get_byte(v[15:8], 1'b1);
      bus_stop();
   endtask

   function automatic logic [15:0] pat(input int r, input int p);
      return 16'(16'h8421 * (p + 1) + r * 16'h0103);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      report();
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [3:0]  a4;
      logic [2:0]  a3;
      logic [7:0]  b;
      bit          ack;
      logic [15:0] shadow [4];

      tick(5);
      rst_n = 1'b1;
      tick(4);
      chk(sda_oe == 1'b0, "R11 line released after reset", 32'(sda_oe), 0);

      // R11 reset values, R5 read word
      for (int r = 0; r < 4; r++) begin
         rd_word(8'(r), v, a3);
         chk(a3 == 3'b111, "R5 read acks", 32'(a3), 32'h7);
         chk(v == 16'hA500 + 16'(r), "R11 reset value", 32'(v), 32'(16'hA500 + 16'(r)));
         shadow[r] = 16'hA500 + 16'(r);
      end

      // R4 write / R3 R5 read back sweep
      for (int p = 0; p < 3; p++) begin
         for (int r = 0; r < 4; r++) begin
            wr_word(8'(r), pat(r, p), a4);
            chk(a4 == 4'b1111, "R4 write acks", 32'(a4), 32'hF);
            shadow[r] = pat(r, p);
         end
         for (int r = 0; r < 4; r++) begin
            rd_word(8'(r), v, a3);
            chk(v == shadow[r], "R3 R5 read back", 32'(v), 32'(shadow[r]));
         end
      end

      // R4 fifth byte refused
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h01, ack);
      put_byte(8'h5A, ack); put_byte(8'hC3, ack);
      put_byte(8'h77, ack);
      bus_stop();
      chk(ack == 1'b0, "R4 extra byte nack", 32'(ack), 0);
      rd_word(8'h01, v, a3);
      chk(v == 16'hC35A, "R4 value after extra byte", 32'(v), 32'hC35A);
      shadow[1] = 16'hC35A;

      // R1 write cut short by stop
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h02, ack); put_byte(8'h99, ack);
      bus_stop();
      rd_word(8'h02, v, a3);
      chk(v == shadow[2], "R1 aborted write leaves reg", 32'(v), 32'(shadow[2]));

      // R1 repeated start in mid write restarts the address phase
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h03, ack); put_byte(8'h11, ack);
      bus_start();
      put_byte(AW_BYTE, ack);
      chk(ack == 1'b1, "R1 repeated start address ack", 32'(ack), 1);
      put_byte(8'h03, ack); put_byte(8'hEE, ack); put_byte(8'h0D, ack);
      bus_stop();
      rd_word(8'h03, v, a3);
      chk(v == 16'h0DEE, "R1 write after repeated start", 32'(v), 32'h0DEE);
      shadow[3] = 16'h0DEE;

      // R6 block read
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h20, ack);
      chk(ack == 1'b1, "R6 block command ack", 32'(ack), 1);
      bus_start();
      put_byte(AR_BYTE, ack);
      get_byte(b, 1'b0);
      chk(b == 8'd6, "R6 count byte", 32'(b), 6);
      for (int k = 0; k < 6; k++) begin
         get_byte(b, k == 5);
         chk(b == 8'(8'h30 + 7 * k), "R6 block data", 32'(b), 32'(8'(8'h30 + 7 * k)));
      end
      bus_stop();

      // R7 block command with data refused
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h20, ack); put_byte(8'h44, ack);
      bus_stop();
      chk(ack == 1'b0, "R7 data after block cmd nack", 32'(ack), 0);

      // R7 unsupported command sweep
      for (int c = 4; c < 64; c++) begin
         if (c == 8'h20) continue;
         bus_start();
         put_byte(AW_BYTE, ack); put_byte(8'(c), ack);
         bus_stop();
         chk(ack == 1'b0, "R7 unsupported command nack", 32'(ack), 0);
      end

      // R8 read without a command
      bus_start();
      put_byte(AR_BYTE, ack);
      bus_stop();
      chk(ack == 1'b0, "R8 read without command nack", 32'(ack), 0);

      // R9 host nack ends the read
      bus_start();
      put_byte(AW_BYTE, ack); put_byte(8'h00, ack);
      bus_start();
      put_byte(AR_BYTE, ack);
      get_byte(b, 1'b1);
      chk(b == shadow[0][7:0], "R9 first byte", 32'(b), 32'(shadow[0][7:0]));
      get_byte(b, 1'b1);
      bus_stop();
      chk(b == 8'hFF, "R9 released after nack", 32'(b), 32'hFF);

      // R2 address sweep
      for (int a = 0; a < 128; a++) begin
         bit a1;
         if (a == 7'h0B) continue;
         bus_start();
         put_byte({7'(a), 1'b0}, a1);
         put_byte(8'h00, ack);
         bus_stop();
         chk(a1 == 1'b0 && ack == 1'b0, "R2 foreign address ignored",
             32'({a1, ack}), 0);
      end

      // R10 disable
      en = 1'b0;
      tick(2);
      chk(sda_oe == 1'b0, "R10 released when disabled", 32'(sda_oe), 0);
      wr_word(8'h00, 16'hDEAD, a4);
      chk(a4 == 4'b0000, "R10 no ack while disabled", 32'(a4), 0);
      en = 1'b1;
      tick(4);
      rd_word(8'h00, v, a3);
      chk(v == shadow[0], "R10 no write while disabled", 32'(v), 32'(shadow[0]));

      // final content check of all words
      for (int r = 0; r < 4; r++) begin
         rd_word(8'(r), v, a3);
         chk(v == shadow[r], "R4 final content", 32'(v), 32'(shadow[r]));
      end

      chk(n_oe_bad == 0, "R12 drive began with clock high", 32'(n_oe_bad), 0);

      report();
      $finish;
   end

endmodule